// File: doc/BRIEF.md
# Cascadable FIFO Depth-Expansion Slice

One slice holds a ring-addressed store of `DEPTH` words of `WIDTH` bits. Several slices chain into one deeper first-in/first-out buffer. All slices share the write strobe, write data and read strobe. Each slice passes a two-bit expansion output to the expansion input of the next slice, and the last slice feeds the first. Exactly one slice has `head_n` tied low; that slice starts as the owner of both the write token and the read token.

A write is stored only by the slice that holds the write token. When that slice stores into its last location, it drives expansion bit 0 high for that cycle. The next slice owns the write token from the following clock edge, so the hand-off loses no cycle. The read token travels the same way on expansion bit 1 when the last location is read. Only the read-token owner drives read data; every other slice drives zero. The composite data bus is therefore the OR of all slice outputs.

Each slice reports active-low full and empty flags. The composite empty flag is the OR of all `empty_n`, and the composite full flag is the AND of all `full_n`. Each token is a two-state machine:

- States: `TOK_WAIT` (the token is held elsewhere) and `TOK_OWN` (this slice holds the token).
- Transitions:
  - reset-to-own: the head slice enters `TOK_OWN` at reset.
  - reset-to-wait: every other slice enters `TOK_WAIT` at reset.
  - hand-off: `TOK_OWN` goes to `TOK_WAIT` on an accepted access at the last location.
  - take: `TOK_WAIT` goes to `TOK_OWN` when the expansion input pulses.
  - self-keep: in a one-slice ring, `TOK_OWN` stays `TOK_OWN` when the slice's own pulse returns.

Top module: `fifo_chain_slice`

## Requirements
- R1: While `rst_n` is low, each slice clears its read pointer, write pointer and word count to zero. After reset, `empty_n` is low, `full_n` is high, and only the slice with `head_n` low owns the two tokens.
- R2: A write strobe is stored only by the slice holding the write token, and only if that slice is not full. All other slices ignore it.
- R3: When the write-token owner stores into its last location (`DEPTH`-1), it drives `xout[0]` high in that same cycle. The slice receiving it on `xin[0]` owns the write token from the next clock edge.
- R4: A slice without the read token drives `rd_data` to zero and ignores read strobes.
- R5: When the read-token owner pops its last location, it drives `xout[1]` high in that cycle, and the next slice owns the read token from the next edge.
- R6: `full_n` is low exactly when the slice holds the write token and all `DEPTH` locations hold unread words. A write in that state is refused, even if a read is accepted in the same cycle.
- R7: `empty_n` is low when the slice lacks the read token or holds no words. A read strobe while the composite buffer is empty changes nothing, and the composite data then reads zero.
- R8: A read and a write accepted in the same cycle leave the word count unchanged. A write into an empty buffer is accepted while the simultaneous read is refused.
- R9: The read-token owner presents its oldest word on `rd_data` combinationally. Across the whole ring, words leave in the order they were written, including after the tokens wrap around the ring more than once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| head_n | input | 1 | Low on the one slice that starts the chain |
| wr_en | input | 1 | Write strobe, shared by all slices |
| wr_data | input | WIDTH | Write data, shared by all slices |
| rd_en | input | 1 | Read strobe, shared by all slices |
| rd_data | output | WIDTH | Oldest word when holding the read token, else zero |
| xin | input | 2 | Token pulses from the previous slice (bit 0 write, bit 1 read) |
| xout | output | 2 | Token pulses to the next slice (bit 0 write, bit 1 read) |
| full_n | output | 1 | Low when holding the write token with every location occupied |
| empty_n | output | 1 | Low when lacking the read token or holding no words |

## Verification
The hardest state to reach is a composite full buffer in which the write token has already gone round the ring. In that state it sits in the same slice as the read token, and that slice holds both the oldest words and the newest ones. The bench first fills all three slices. It then pops a hundred words and writes a hundred more, so that the head slice becomes full a second time with its read and write pointers away from zero. After that, a long stretch of mixed and simultaneous strobes moves both tokens round the ring several times, and every cycle is compared with an arithmetic model of indices.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
    typedef enum logic {
        TOK_WAIT = 1'b0,
        TOK_OWN  = 1'b1
    } tok_state_t;

    localparam int XBIT_WR = 0;
    localparam int XBIT_RD = 1;
    localparam int NUM_CH  = 2;
endpackage

// File: rtl/chain_token_fsm.sv
module chain_token_fsm
    import fifo_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_head,
    input  logic step,
    input  logic at_last,
    input  logic pass_in,
    output logic own,
    output logic pass_out
);
    tok_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= is_head ? TOK_OWN : TOK_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_OWN:  if (step && at_last && !pass_in) state_d = TOK_WAIT;
            TOK_WAIT: if (pass_in)                     state_d = TOK_OWN;
            default:                                   state_d = TOK_WAIT;
        endcase
    end

    always_comb begin
        own      = (state_q == TOK_OWN);
        pass_out = own && step && at_last;
    end

    // R3 R5: a hand-off to another slice leaves this slice without the token
    p_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_out && !pass_in) |=> !own);
    // R3 R5: an incoming pulse is always taken
    p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!own && pass_in) |=> own);
endmodule

// File: rtl/chain_ring_ptr.sv
module chain_ring_ptr #(
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [AW-1:0] ptr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= at_last ? '0 : ptr + AW'(1);
    end

    assign at_last = (ptr == LAST);

    // R1: the pointer never leaves the slice's address range
    p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
endmodule

// File: rtl/chain_store.sv
module chain_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_chain_slice.sv
module fifo_chain_slice
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [1:0]       xin,
    output logic [1:0]       xout,
    output logic             full_n,
    output logic             empty_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [CW-1:0]       count_q;
    logic [NUM_CH-1:0]   fire, own, at_last;
    logic [AW-1:0]       ptr [NUM_CH];
    logic [WIDTH-1:0]    mem_rdata;
    logic                has_words, is_full;

    assign has_words = (count_q != '0);
    assign is_full   = (count_q == CNT_FULL);

    assign fire[XBIT_WR] = wr_en && own[XBIT_WR] && !is_full;
    assign fire[XBIT_RD] = rd_en && own[XBIT_RD] && has_words;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        chain_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (fire[ch]),
            .ptr     (ptr[ch]),
            .at_last (at_last[ch])
        );

        chain_token_fsm u_tok (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_head  (!head_n),
            .step     (fire[ch]),
            .at_last  (at_last[ch]),
            .pass_in  (xin[ch]),
            .own      (own[ch]),
            .pass_out (xout[ch])
        );
    end

    chain_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (fire[XBIT_WR]),
        .waddr (ptr[XBIT_WR]),
        .wdata (wr_data),
        .raddr (ptr[XBIT_RD]),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case ({fire[XBIT_WR], fire[XBIT_RD]})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    always_comb begin
        full_n  = !(own[XBIT_WR] && is_full);
        empty_n = own[XBIT_RD] && has_words;
        rd_data = empty_n ? mem_rdata : '0;
    end

    // R1: flags take their reset values on the first cycle after reset
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!empty_n && full_n && (own[XBIT_WR] == !head_n)));
    // R6: the word count never exceeds the slice depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_FULL);
    // R6: a full slice stays full unless a read is taken
    p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !fire[XBIT_RD]) |=> (count_q == CNT_FULL));
    // R7: an empty slice stays empty unless a write is taken
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_words && !fire[XBIT_WR]) |=> !has_words);
    // R4: a slice without the read token keeps its data output at zero
    p_quiet_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !own[XBIT_RD] |-> (rd_data == '0));
    // R8: simultaneous accepted read and write keep the count
    p_both_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[XBIT_WR] && fire[XBIT_RD]) |=> $stable(count_q));
endmodule

// File: tb/fifo_chain_slice_tb.sv
module fifo_chain_slice_tb;
    localparam int W     = 9;
    localparam int D     = 256;
    localparam int N     = 3;
    localparam int TOTAL = D * N;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, wr_en, rd_en;
    logic [W-1:0] wr_data;
    logic [N-1:0][1:0]   xo;
    logic [N-1:0][W-1:0] rd_s;
    logic [N-1:0]        full_s, empty_s;
    logic [W-1:0] comp_data;
    logic comp_full_n, comp_empty_n;

    for (genvar g = 0; g < N; g++) begin : g_slice
        fifo_chain_slice #(.WIDTH(W), .DEPTH(D)) u_dut (
            .clk     (clk),
            .rst_n   (rst_n),
            .head_n  ((g == 0) ? 1'b0 : 1'b1),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .rd_en   (rd_en),
            .rd_data (rd_s[g]),
            .xin     (xo[(g + N - 1) % N]),
            .xout    (xo[g]),
            .full_n  (full_s[g]),
            .empty_n (empty_s[g])
        );
    end

    always_comb begin
        comp_data    = '0;
        comp_full_n  = 1'b1;
        comp_empty_n = 1'b0;
        for (int s = 0; s < N; s++) begin
            comp_data    = comp_data | rd_s[s];
            comp_full_n  = comp_full_n & full_s[s];
            comp_empty_n = comp_empty_n | empty_s[s];
        end
    end

    int checks = 0, failures = 0;
    int wr_idx = 0, rd_idx = 0;
    bit done = 1'b0;

    function automatic logic [W-1:0] val(input int i);
        return W'((i * 37 + 5) % (1 << W));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (wr=%0d rd=%0d)", req, act, exp, wr_idx, rd_idx);
        end
    endtask

    task automatic op(input bit we, input bit re);
        bit efull, eempty, wa, ra;
        int wslc, rslc;
        wr_en   = we;
        rd_en   = re;
        wr_data = val(wr_idx);
        #1;
        efull  = (wr_idx - rd_idx) == TOTAL;
        eempty = (wr_idx == rd_idx);
        wslc   = (wr_idx / D) % N;
        rslc   = (rd_idx / D) % N;
        wa     = we && !efull;
        ra     = re && !eempty;
        check(comp_full_n == !efull, "R6 composite full_n", int'(comp_full_n), int'(!efull));
        check(comp_empty_n == !eempty, "R7 composite empty_n", int'(comp_empty_n), int'(!eempty));
        // R2 R9: oldest word in order, zero when empty (R7)
        check(comp_data == (eempty ? '0 : val(rd_idx)), "R9 read data", int'(comp_data),
              eempty ? 0 : int'(val(rd_idx)));
        for (int s = 0; s < N; s++) begin
            if (s != rslc)
                check(rd_s[s] == '0, "R4 non-owner data zero", int'(rd_s[s]), 0);
            check(full_s[s] == !(efull && s == wslc), "R6 slice full_n",
                  int'(full_s[s]), int'(!(efull && s == wslc)));
            check(empty_s[s] == (!eempty && s == rslc), "R7 slice empty_n",
                  int'(empty_s[s]), int'(!eempty && s == rslc));
            check(xo[s][0] == (wa && (wr_idx % D == D - 1) && s == wslc), "R3 write pass pulse",
                  int'(xo[s][0]), int'(wa && (wr_idx % D == D - 1) && s == wslc));
            check(xo[s][1] == (ra && (rd_idx % D == D - 1) && s == rslc), "R5 read pass pulse",
                  int'(xo[s][1]), int'(ra && (rd_idx % D == D - 1) && s == rslc));
        end
        @(negedge clk);
        if (wa) wr_idx++;
        if (ra) rd_idx++;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, one slice owns both tokens, all empty
        for (int i = 0; i < 3; i++) op(1'b0, 1'b0);
        // R7: read of an empty buffer is ignored
        op(1'b0, 1'b1);
        // R2 R3: fill all three slices
        for (int i = 0; i < TOTAL; i++) op(1'b1, 1'b0);
        // R6: write while full is refused
        op(1'b1, 1'b0);
        // R6 R8: full with simultaneous read: only the read is taken
        op(1'b1, 1'b1);
        // R5: drain part, then refill so the write token wraps into a slice with unread words
        for (int i = 0; i < 99; i++) op(1'b0, 1'b1);
        for (int i = 0; i < 100; i++) op(1'b1, 1'b0);
        op(1'b1, 1'b0);
        // R8 R9: mixed and simultaneous traffic around the ring
        for (int i = 0; i < 6000; i++) op((i % 3) != 0, (i % 2) == 0 || (i % 7) == 3);
        for (int i = 0; i < 2500; i++) op(1'b1, 1'b1);
        // R5 R9: drain to empty, then R8 write into empty with read
        while (wr_idx != rd_idx) op(1'b0, 1'b1);
        op(1'b0, 1'b1);
        op(1'b1, 1'b1);
        op(1'b0, 1'b1);
        op(1'b0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule